// File: doc/BRIEF.md
# Planar Graphics Memory Datapath

This block is the byte-wide data path between a CPU and four parallel 8-bit display memory planes. It suits a 16-colour planar frame buffer, where one CPU address selects one byte in each plane. Software programs two registers through a small indexed port. The rotate/function register holds a right-rotate count and a logical function code. The plane-select register names the plane that CPU reads return.

Every CPU read loads a bank of per-plane latches with the bytes presented by memory. The same read returns one of those bytes, chosen by the plane-select register or by the low CPU address bits, depending on the addressing mode. On a CPU write, the byte is rotated right when the write mode is 0. It is then combined with each plane's latch using the programmed function, and the per-plane results go out to all planes in the same cycle. The surrounding controller owns the memory timing. It presents the plane bytes for the current address combinationally and applies `plane_wdata` when `plane_we` is high.

Top module: `planar_datapath`

## Requirements
- R1: A register write with `reg_index` = 3 stores `reg_wdata[2:0]` as the rotate count and `reg_wdata[4:3]` as the function code, effective from the next clock. While `reg_index` = 3, `reg_rdata` shows `{3'b000, function, count}`.
- R2: A register write with `reg_index` = 4 stores `reg_wdata[1:0]` as the plane select. While `reg_index` = 4, `reg_rdata` shows `{6'b0, select}`. A write at any other index changes neither register, and any other index reads as 0.
- R3: After reset, the rotate count, the function code, the plane select and all four latches are 0.
- R4: When `wr_mode` = 0, the CPU write byte is rotated right by the count, from 0 to 7 positions, before it is combined.
- R5: The function code selects the combination of the (rotated) byte with the latch of the plane being written: 0 passes the byte, 1 ANDs, 2 ORs and 3 XORs. Plane k's result appears on `plane_wdata[8k+7:8k]`.
- R6: On a clock with `cpu_rd` high, latch k loads `plane_rdata[8k+7:8k]`. At all other times the latches hold, including across CPU writes.
- R7: When `wr_mode` is not 0, the byte is not rotated, but the function code still applies.
- R8: With `odd_even` and `quad` both low, `cpu_rdata` is the byte of the plane named by the plane select.
- R9: With `odd_even` high and `quad` low, `cpu_rdata` comes from plane {select[1], `cpu_addr[0]`}, so select bit 0 has no effect.
- R10: With `quad` high, whatever `odd_even` is, `cpu_rdata` comes from plane `cpu_addr[1:0]`, so both select bits have no effect.
- R11: `plane_we` is high in exactly the cycles in which `cpu_wr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_index | input | 8 | Register index for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_index` |
| wr_mode | input | 2 | Write mode field; the rotate applies only when 0 |
| odd_even | input | 1 | Odd/even addressing mode |
| quad | input | 1 | Quad addressing mode, wins over odd/even |
| cpu_rd | input | 1 | CPU read cycle |
| cpu_wr | input | 1 | CPU write cycle |
| cpu_addr | input | 2 | Low CPU address bits |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | CPU read byte |
| plane_rdata | input | 32 | Bytes of planes 3..0 at the current address |
| plane_wdata | output | 32 | Bytes to write to planes 3..0 |
| plane_we | output | 1 | Plane write enable |

## Verification
The bench builds the block with its default parameters: 8-bit planes, four planes and 8-bit registers. These give the full 0-to-7 rotate range, all four function codes and a 2-bit plane index. At that index width, the odd/even mode substitution and the quad mode address pass-through are distinct from plain selection. A behavioural model of the memory and of the latches then shows that read-then-write sequences leave the expected plane contents, and that writes do not disturb the latches.

// File: rtl/pgd_pkg.sv
package pgd_pkg;
   typedef enum logic [1:0] {
      FN_PASS = 2'd0,
      FN_AND  = 2'd1,
      FN_OR   = 2'd2,
      FN_XOR  = 2'd3
   } logic_fn_e;
endpackage

// File: rtl/pgd_regs.sv
module pgd_regs
   import pgd_pkg::*;
#(
   parameter int REG_W      = 8,
   parameter int ROT_W      = 3,
   parameter int PSEL_W     = 2,
   parameter int IDX_ROTATE = 3,
   parameter int IDX_MAPSEL = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_W-1:0]  reg_index,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   output logic [ROT_W-1:0]  rot_cnt,
   output logic_fn_e         fn_sel,
   output logic [PSEL_W-1:0] map_sel
);
   localparam int FN_LSB = ROT_W;
   localparam logic [REG_W-1:0] IDX_ROT_L = REG_W'(IDX_ROTATE);
   localparam logic [REG_W-1:0] IDX_MAP_L = REG_W'(IDX_MAPSEL);

   logic hit_rot, hit_map;
   logic unused_wbits;

   assign hit_rot = (reg_index == IDX_ROT_L);
   assign hit_map = (reg_index == IDX_MAP_L);
   assign unused_wbits = ^reg_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rot_cnt <= '0;
         fn_sel  <= FN_PASS;
         map_sel <= '0;
      end else if (reg_we) begin
         if (hit_rot) begin
            rot_cnt <= reg_wdata[ROT_W-1:0];
            fn_sel  <= logic_fn_e'(reg_wdata[FN_LSB+1:FN_LSB]);
         end
         if (hit_map) begin
            map_sel <= reg_wdata[PSEL_W-1:0];
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (hit_rot) begin
         reg_rdata[ROT_W-1:0]         = rot_cnt;
         reg_rdata[FN_LSB+1:FN_LSB]   = fn_sel;
      end else if (hit_map) begin
         reg_rdata[PSEL_W-1:0]        = map_sel;
      end
   end
endmodule

// File: rtl/pgd_rotate.sv
module pgd_rotate #(
   parameter int DATA_W = 8,
   parameter int ROT_W  = 3
) (
   input  logic [DATA_W-1:0] din,
   input  logic [ROT_W-1:0]  cnt,
   output logic [DATA_W-1:0] dout
);
   logic [DATA_W-1:0] stage [ROT_W+1];

   assign stage[0] = din;

   for (genvar s = 0; s < ROT_W; s++) begin : g_stage
      localparam int SH = 2 ** s;
      assign stage[s+1] = cnt[s] ? {stage[s][SH-1:0], stage[s][DATA_W-1:SH]}
                                 : stage[s];
   end

   assign dout = stage[ROT_W];
endmodule

// File: rtl/pgd_write_path.sv
module pgd_write_path
   import pgd_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int NUM_PLANES = 4,
   parameter int ROT_W      = 3
) (
   input  logic [DATA_W-1:0]            cpu_wdata,
   input  logic [ROT_W-1:0]             rot_cnt,
   input  logic                         rot_en,
   input  logic_fn_e                    fn_sel,
   input  logic [DATA_W*NUM_PLANES-1:0] lat_bus,
   output logic [DATA_W*NUM_PLANES-1:0] plane_wdata
);
   logic [ROT_W-1:0]  eff_cnt;
   logic [DATA_W-1:0] rotated;

   assign eff_cnt = rot_en ? rot_cnt : '0;

   pgd_rotate #(
      .DATA_W (DATA_W),
      .ROT_W  (ROT_W)
   ) u_rotate (
      .din  (cpu_wdata),
      .cnt  (eff_cnt),
      .dout (rotated)
   );

   for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
      logic [DATA_W-1:0] lat_b, res_b;
      assign lat_b = lat_bus[p*DATA_W +: DATA_W];
      always_comb begin
         unique case (fn_sel)
            FN_AND:  res_b = rotated & lat_b;
            FN_OR:   res_b = rotated | lat_b;
            FN_XOR:  res_b = rotated ^ lat_b;
            default: res_b = rotated;
         endcase
      end
      assign plane_wdata[p*DATA_W +: DATA_W] = res_b;
   end
endmodule

// File: rtl/pgd_read_path.sv
module pgd_read_path #(
   parameter int DATA_W     = 8,
   parameter int NUM_PLANES = 4,
   parameter int PSEL_W     = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cpu_rd,
   input  logic [DATA_W*NUM_PLANES-1:0] plane_rdata,
   input  logic [PSEL_W-1:0]            map_sel,
   input  logic [PSEL_W-1:0]            cpu_addr,
   input  logic                         odd_even,
   input  logic                         quad,
   output logic [DATA_W-1:0]            cpu_rdata,
   output logic [DATA_W*NUM_PLANES-1:0] lat_bus
);
   logic [DATA_W-1:0] plane_b [NUM_PLANES];
   logic [PSEL_W-1:0] pidx;

   for (genvar p = 0; p < NUM_PLANES; p++) begin : g_split
      assign plane_b[p] = plane_rdata[p*DATA_W +: DATA_W];
   end

   always_comb begin
      pidx = map_sel;
      if (quad) begin
         pidx = cpu_addr;
      end else if (odd_even) begin
         pidx[0] = cpu_addr[0];
      end
   end

   assign cpu_rdata = plane_b[pidx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_bus <= '0;
      end else if (cpu_rd) begin
         lat_bus <= plane_rdata;
      end
   end
endmodule

// File: rtl/planar_datapath.sv
module planar_datapath
   import pgd_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int NUM_PLANES = 4,
   parameter int REG_W      = 8,
   parameter int WMODE_W    = 2,
   parameter int IDX_ROTATE = 3,
   parameter int IDX_MAPSEL = 4,
   localparam int ROT_W     = $clog2(DATA_W),
   localparam int PSEL_W    = $clog2(NUM_PLANES),
   localparam int BUS_W     = DATA_W * NUM_PLANES
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_we,
   input  logic [REG_W-1:0]   reg_index,
   input  logic [REG_W-1:0]   reg_wdata,
   output logic [REG_W-1:0]   reg_rdata,
   input  logic [WMODE_W-1:0] wr_mode,
   input  logic               odd_even,
   input  logic               quad,
   input  logic               cpu_rd,
   input  logic               cpu_wr,
   input  logic [PSEL_W-1:0]  cpu_addr,
   input  logic [DATA_W-1:0]  cpu_wdata,
   output logic [DATA_W-1:0]  cpu_rdata,
   input  logic [BUS_W-1:0]   plane_rdata,
   output logic [BUS_W-1:0]   plane_wdata,
   output logic               plane_we
);
   if (DATA_W < 2 || (1 << ROT_W) != DATA_W) begin : g_bad_data_w
      $error("DATA_W must be a power of two of at least 2");
   end
   if (NUM_PLANES < 2 || (1 << PSEL_W) != NUM_PLANES) begin : g_bad_planes
      $error("NUM_PLANES must be a power of two of at least 2");
   end
   if (REG_W < ROT_W + 2 || REG_W < PSEL_W) begin : g_bad_reg_w
      $error("REG_W too narrow for the register fields");
   end
   if (IDX_ROTATE == IDX_MAPSEL || IDX_ROTATE >= (1 << REG_W)
       || IDX_MAPSEL >= (1 << REG_W)) begin : g_bad_idx
      $error("register indices must differ and fit in REG_W");
   end
   if (WMODE_W < 1) begin : g_bad_wmode
      $error("WMODE_W must be at least 1");
   end

   logic [ROT_W-1:0]  rot_cnt;
   logic_fn_e         fn_sel;
   logic [PSEL_W-1:0] map_sel;
   logic [BUS_W-1:0]  lat_bus;

   pgd_regs #(
      .REG_W      (REG_W),
      .ROT_W      (ROT_W),
      .PSEL_W     (PSEL_W),
      .IDX_ROTATE (IDX_ROTATE),
      .IDX_MAPSEL (IDX_MAPSEL)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_index (reg_index),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .rot_cnt   (rot_cnt),
      .fn_sel    (fn_sel),
      .map_sel   (map_sel)
   );

   pgd_read_path #(
      .DATA_W     (DATA_W),
      .NUM_PLANES (NUM_PLANES),
      .PSEL_W     (PSEL_W)
   ) u_read (
      .clk         (clk),
      .rst_n       (rst_n),
      .cpu_rd      (cpu_rd),
      .plane_rdata (plane_rdata),
      .map_sel     (map_sel),
      .cpu_addr    (cpu_addr),
      .odd_even    (odd_even),
      .quad        (quad),
      .cpu_rdata   (cpu_rdata),
      .lat_bus     (lat_bus)
   );

   pgd_write_path #(
      .DATA_W     (DATA_W),
      .NUM_PLANES (NUM_PLANES),
      .ROT_W      (ROT_W)
   ) u_write (
      .cpu_wdata   (cpu_wdata),
      .rot_cnt     (rot_cnt),
      .rot_en      (wr_mode == '0),
      .fn_sel      (fn_sel),
      .lat_bus     (lat_bus),
      .plane_wdata (plane_wdata)
   );

   assign plane_we = cpu_wr;
endmodule

// File: rtl/pgd_checker.sv
module pgd_checker
   import pgd_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int NUM_PLANES = 4,
   parameter int REG_W      = 8,
   parameter int WMODE_W    = 2,
   parameter int IDX_ROTATE = 3,
   parameter int IDX_MAPSEL = 4,
   parameter int ROT_W      = 3,
   parameter int PSEL_W     = 2
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         cpu_rd,
   input logic                         cpu_wr,
   input logic [WMODE_W-1:0]           wr_mode,
   input logic                         quad,
   input logic [PSEL_W-1:0]            cpu_addr,
   input logic [REG_W-1:0]             reg_index,
   input logic [REG_W-1:0]             reg_rdata,
   input logic [DATA_W-1:0]            cpu_wdata,
   input logic [DATA_W*NUM_PLANES-1:0] plane_rdata,
   input logic [DATA_W*NUM_PLANES-1:0] plane_wdata,
   input logic [DATA_W-1:0]            cpu_rdata,
   input logic [DATA_W*NUM_PLANES-1:0] lat_bus,
   input logic_fn_e                    fn_sel
);
   logic [DATA_W-1:0] addr_byte;
   logic [DATA_W*NUM_PLANES-1:0] wd_rep;

   assign addr_byte = plane_rdata[int'(cpu_addr)*DATA_W +: DATA_W];
   assign wd_rep    = {NUM_PLANES{cpu_wdata}};

   a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_index == REG_W'(IDX_ROTATE)) |-> (reg_rdata[REG_W-1:ROT_W+2] == '0));

   a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_index == REG_W'(IDX_MAPSEL)) |-> (reg_rdata[REG_W-1:PSEL_W] == '0));

   a_r6_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rd |=> (lat_bus == $past(plane_rdata)));

   a_r6_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_rd |=> $stable(lat_bus));

   a_r7_xor_unrotated: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && wr_mode != '0 && fn_sel == FN_XOR) |-> (plane_wdata == (wd_rep ^ lat_bus)));

   a_r7_pass_unrotated: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && wr_mode != '0 && fn_sel == FN_PASS) |-> (plane_wdata == wd_rep));

   a_r10_quad_select: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd && quad) |-> (cpu_rdata == addr_byte));
endmodule

bind planar_datapath pgd_checker #(
   .DATA_W     (DATA_W),
   .NUM_PLANES (NUM_PLANES),
   .REG_W      (REG_W),
   .WMODE_W    (WMODE_W),
   .IDX_ROTATE (IDX_ROTATE),
   .IDX_MAPSEL (IDX_MAPSEL),
   .ROT_W      (ROT_W),
   .PSEL_W     (PSEL_W)
) u_pgd_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .cpu_rd      (cpu_rd),
   .cpu_wr      (cpu_wr),
   .wr_mode     (wr_mode),
   .quad        (quad),
   .cpu_addr    (cpu_addr),
   .reg_index   (reg_index),
   .reg_rdata   (reg_rdata),
   .cpu_wdata   (cpu_wdata),
   .plane_rdata (plane_rdata),
   .plane_wdata (plane_wdata),
   .cpu_rdata   (cpu_rdata),
   .lat_bus     (lat_bus),
   .fn_sel      (fn_sel)
);

// File: tb/test_planar_datapath.sv
module test_planar_datapath;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_index = 8'd0;
   logic [7:0]  reg_wdata = 8'd0;
   logic [7:0]  reg_rdata;
   logic [1:0]  wr_mode = 2'd0;
   logic        odd_even = 1'b0;
   logic        quad = 1'b0;
   logic        cpu_rd = 1'b0;
   logic        cpu_wr = 1'b0;
   logic [3:0]  cur_addr = 4'd0;
   logic [7:0]  cpu_wdata = 8'd0;
   logic [7:0]  cpu_rdata;
   logic [31:0] plane_rdata;
   logic [31:0] plane_wdata;
   logic        plane_we;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [7:0] mem [4][16];
   int m_rot, m_fn, m_sel;
   int m_lat [4];

   always #10 clk = ~clk;

   planar_datapath i_planar_datapath (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_index(reg_index),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wr_mode(wr_mode),
      .odd_even(odd_even), .quad(quad), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
      .cpu_addr(cur_addr[1:0]), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .plane_rdata(plane_rdata), .plane_wdata(plane_wdata), .plane_we(plane_we)
   );

   // environment: memory planes
   always_comb begin
      for (int p = 0; p < 4; p++) plane_rdata[p*8 +: 8] = mem[p][cur_addr];
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int p = 0; p < 4; p++)
            for (int a = 0; a < 16; a++)
               mem[p][a] <= 8'(p*53 + a*29 + 23);
      end else if (plane_we) begin
         for (int p = 0; p < 4; p++) mem[p][cur_addr] <= plane_wdata[p*8 +: 8];
      end
   end

   // reference model state
   always @(posedge clk) begin
      if (!rst_n) begin
         m_rot = 0; m_fn = 0; m_sel = 0;
         for (int p = 0; p < 4; p++) m_lat[p] = 0;
      end else begin
         if (reg_we && reg_index == 8'd3) begin
            m_rot = reg_wdata & 7;
            m_fn  = (reg_wdata >> 3) & 3;
         end
         if (reg_we && reg_index == 8'd4) m_sel = reg_wdata & 3;
         if (cpu_rd)
            for (int p = 0; p < 4; p++) m_lat[p] = mem[p][cur_addr];
      end
   end

   function automatic int rotr(int d, int n);
      return ((d >> n) | (d << (8 - n))) & 255;
   endfunction

   function automatic int combine(int d, int l, int f);
      case (f)
         1: return d & l;
         2: return d | l;
         3: return d ^ l;
         default: return d;
      endcase
   endfunction

   task automatic chk(string tag, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // per-clock comparison against the model, mid cycle
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R11", int'(plane_we), int'(cpu_wr));
         if (reg_index == 8'd3)      chk("R1", int'(reg_rdata), m_rot | (m_fn << 3));
         else if (reg_index == 8'd4) chk("R2", int'(reg_rdata), m_sel);
         else                        chk("R2", int'(reg_rdata), 0);
         if (cpu_rd) begin
            int pi;
            pi = quad ? (cur_addr & 3) : odd_even ? ((m_sel & 2) | (cur_addr & 1)) : m_sel;
            chk(quad ? "R10" : odd_even ? "R9" : "R8", int'(cpu_rdata), int'(mem[pi][cur_addr]));
         end
         if (cpu_wr) begin
            for (int p = 0; p < 4; p++) begin
               int d;
               d = (wr_mode == 2'd0) ? rotr(cpu_wdata, m_rot) : int'(cpu_wdata);
               chk(wr_mode != 0 ? "R7" : (m_fn == 0 ? "R4" : "R5"),
                   int'(plane_wdata[p*8 +: 8]), combine(d, m_lat[p], m_fn));
            end
         end
      end
   end

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic reg_wr(int idx, int val);
      reg_we = 1'b1; reg_index = 8'(idx); reg_wdata = 8'(val);
      step();
      reg_we = 1'b0;
   endtask

   task automatic reg_chk(int idx, int exp, string tag);
      reg_index = 8'(idx);
      #3;
      chk(tag, int'(reg_rdata), exp);
   endtask

   task automatic cpu_read(int a);
      cpu_rd = 1'b1; cur_addr = 4'(a);
      step();
      cpu_rd = 1'b0;
   endtask

   task automatic cpu_write(int a, int d);
      cpu_wr = 1'b1; cur_addr = 4'(a); cpu_wdata = 8'(d);
      step();
      cpu_wr = 1'b0;
      #1;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      #(20 * 100000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [7:0] snap [4];
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      step();

      // R3: reset state of registers and latches
      reg_chk(3, 0, "R3");
      reg_chk(4, 0, "R3");
      reg_wr(3, 8'h10);               // OR, rotate 0
      cpu_write(15, 8'h00);
      for (int p = 0; p < 4; p++) chk("R3", int'(mem[p][15]), 0);

      // R1 / R2: field storage, reserved bits, foreign index
      reg_wr(3, 8'hFF);
      reg_chk(3, 8'h1F, "R1");
      reg_wr(4, 8'hFF);
      reg_chk(4, 8'h03, "R2");
      reg_wr(5, 8'hAA);
      reg_chk(3, 8'h1F, "R2");
      reg_chk(4, 8'h03, "R2");
      reg_chk(5, 0, "R2");

      // R4: rotate sweep with pass function
      for (int n = 0; n < 8; n++) begin
         reg_wr(3, n);
         cpu_write(n, 8'hB4);
         chk("R4", int'(mem[n & 3][n]), rotr(8'hB4, n));
      end

      // R5: read-then-write with each function code, rotate 3
      for (int f = 0; f < 4; f++) begin
         for (int p = 0; p < 4; p++) snap[p] = mem[p][8 + f];
         cpu_read(8 + f);
         reg_wr(3, (f << 3) | 3);
         cpu_write(8 + f, 8'h3C);
         for (int p = 0; p < 4; p++)
            chk("R5", int'(mem[p][8 + f]), combine(rotr(8'h3C, 3), snap[p], f));
      end

      // R6: latches hold across writes
      for (int p = 0; p < 4; p++) snap[p] = mem[p][4];
      cpu_read(4);
      reg_wr(3, 8'h18);               // XOR, rotate 0
      cpu_write(5, 8'h00);
      cpu_write(6, 8'h00);
      for (int p = 0; p < 4; p++) begin
         chk("R6", int'(mem[p][5]), int'(snap[p]));
         chk("R6", int'(mem[p][6]), int'(snap[p]));
      end

      // R7: rotate bypassed in other write modes, function kept
      wr_mode = 2'd1;
      reg_wr(3, 8'h05);               // pass, rotate 5
      cpu_write(7, 8'h81);
      for (int p = 0; p < 4; p++) chk("R7", int'(mem[p][7]), 8'h81);
      wr_mode = 2'd2;
      for (int p = 0; p < 4; p++) snap[p] = mem[p][12];
      cpu_read(12);
      reg_wr(3, 8'h0E);               // AND, rotate 6
      cpu_write(13, 8'hC3);
      for (int p = 0; p < 4; p++) chk("R7", int'(mem[p][13]), 8'hC3 & snap[p]);
      wr_mode = 2'd0;

      // R8 / R9 / R10: read plane selection in each addressing mode
      for (int m = 0; m < 4; m++) begin
         odd_even = m[0];
         quad     = m[1];
         for (int s = 0; s < 4; s++) begin
            reg_wr(4, s);
            for (int a = 0; a < 4; a++) cpu_read(a + 4 * s);
         end
      end
      odd_even = 1'b0;
      quad = 1'b0;

      step();
      finish_run();
   end
endmodule